// File: doc/BRIEF.md
# Pulse-Swallowing Minute Trim Divider

This block divides an oscillator clock down to a fast stage, seconds and minutes. Once per minute it deletes a programmable number of fast-stage pulses to correct a crystal that always runs fast. The crystal is deliberately pulled so that its error is positive only. A 6-bit trim value `n` then removes `n` fast pulses each minute, and each step is worth about 2.03 ppm at the nominal rates. The deletion happens inside a window that opens a fixed number of fast periods into the first second of every minute. With the default sizes that point is about 100 ms after the minute boundary, and the first window follows reset release by the same delay. The pulses are removed by holding the fast-stage enable low for `n` consecutive fast slots, so the slower stages only ever see a clean, delayed enable.

A check mode lets a tester read the trim value with a period meter. A check tick is produced every `CHK_BASE + n` nominal (uncorrected) fast periods. With the defaults this is 31.25 ms plus n × 122 µs, which is the motor period at 1024 times its normal rate. Calibration can be switched off completely, for example while a ground-tied test mode is active.

Top module: `timebase_trim`

## Requirements
- R1: While `rst_n` is low and for two clocks after it rises, every output is 0. The first `fast_tick_o` is high in the clock cycle that follows the (2 + PRE_DIV − 1)th rising edge after release.
- R2: With no deletion pending, `fast_tick_o` is a single-cycle pulse once every PRE_DIV clocks.
- R3: `sec_tick_o` is high together with every FAST_PER_SEC-th `fast_tick_o`. `min_tick_o` is high together with every SEC_PER_MIN-th `sec_tick_o`. A minute therefore lasts PRE_DIV × (FAST_PER_SEC × SEC_PER_MIN + n) clocks, where `n` is the unsigned 6-bit `cal_i` (0 to 63) that was captured for that minute.
- R4: Deletion starts only in second 0 of a minute, right after the WIN_START-th `fast_tick_o` of that second. It then removes the next `n` nominal fast slots in a row. The minute that starts at reset release also gets this correction.
- R5: `cal_i` is captured only when the window opens. A change made later in the minute affects the next minute and not the current one.
- R6: With `cal_en_i` low, a captured value counts as 0, and a deletion already in progress stops from the next clock on.
- R7: With `chk_mode_i` high, `chk_tick_o` pulses once every PRE_DIV × (CHK_BASE + `cal_i`) clocks. These are nominal fast periods, unaffected by deletion.
- R8: With `chk_mode_i` low, `chk_tick_o` stays 0 and the check period counter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously |
| cal_i | input | 6 | trim value n, unsigned |
| cal_en_i | input | 1 | calibration enable; low disables all deletion |
| chk_mode_i | input | 1 | selects trim-readout period generation |
| fast_tick_o | output | 1 | corrected fast-stage enable pulse |
| sec_tick_o | output | 1 | one-second pulse |
| min_tick_o | output | 1 | one-minute pulse |
| chk_tick_o | output | 1 | check-period pulse |

## Verification
Every tick is a combinational decode of registered counters, so a tick is visible in the cycle right after the clock edge that moves its counter. The bench samples on the falling edge and counts rising edges from a known event. The first fast tick is due 5 edges after reset release, the first second tick after 77 and the first minute tick after 269, using the bench sizes with n = 3. Minute and check intervals are measured edge to edge between consecutive pulses, so the interval is exactly PRE_DIV times the number of nominal fast slots. New inputs are applied just after a minute tick, so the next window captures them. An abort is judged by the number of edges until the next fast tick, which must be no more than PRE_DIV.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int CAL_W = 6;
  typedef logic [CAL_W-1:0] cal_t;
endpackage

// File: rtl/tt_modcnt.sv
module tt_modcnt #(
  parameter int LIMIT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_i,
  output logic                       wrap_o,
  output logic [$clog2(LIMIT)-1:0]   cnt_o
);
  localparam int W = $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign wrap_o = en_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tt_swallow.sv
module tt_swallow
  import tt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw_tick_i,
  input  logic open_i,
  input  logic cal_en_i,
  input  cal_t cal_i,
  output cal_t rem_o,
  output logic hold_o
);
  cal_t rem_q, rem_d;

  assign rem_o  = rem_q;
  assign hold_o = (rem_q != '0);

  always_comb begin
    rem_d = rem_q;
    if (!cal_en_i)                   rem_d = '0;
    else if (open_i)                 rem_d = cal_i;
    else if (raw_tick_i && hold_o)   rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end
endmodule

// File: rtl/tt_check.sv
module tt_check
  import tt_pkg::*;
#(
  parameter int BASE = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic raw_tick_i,
  input  cal_t cal_i,
  output logic tick_o
);
  localparam int CW = $clog2(BASE + (1 << CAL_W) + 1);

  logic [CW-1:0] cnt_q, cnt_d, last;

  assign last   = CW'(BASE - 1) + CW'(cal_i);
  assign tick_o = mode_i && raw_tick_i && (cnt_q >= last);

  always_comb begin
    cnt_d = cnt_q;
    if (!mode_i)         cnt_d = '0;
    else if (tick_o)     cnt_d = '0;
    else if (raw_tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/timebase_trim.sv
module timebase_trim
  import tt_pkg::*;
#(
  parameter int PRE_DIV      = 4,
  parameter int FAST_PER_SEC = 8192,
  parameter int SEC_PER_MIN  = 60,
  parameter int WIN_START    = 819,
  parameter int CHK_BASE     = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAL_W-1:0] cal_i,
  input  logic             cal_en_i,
  input  logic             chk_mode_i,
  output logic             fast_tick_o,
  output logic             sec_tick_o,
  output logic             min_tick_o,
  output logic             chk_tick_o
);
  localparam int PW = $clog2(PRE_DIV);
  localparam int FW = $clog2(FAST_PER_SEC);
  localparam int SW = $clog2(SEC_PER_MIN);
  localparam logic [FW-1:0] WIN_LAST = FW'(WIN_START - 1);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic          raw_tick, cor_tick, sec_tick, min_tick, hold, win_open, in_sec0;
  logic [PW-1:0] pre_cnt;
  logic [FW-1:0] fast_cnt;
  logic [SW-1:0] sec_cnt;
  cal_t          rem;

  tt_modcnt #(.LIMIT(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_core_n), .en_i(1'b1), .wrap_o(raw_tick), .cnt_o(pre_cnt));

  assign cor_tick = raw_tick && !hold;

  tt_modcnt #(.LIMIT(FAST_PER_SEC)) u_fast (
    .clk(clk), .rst_n(rst_core_n), .en_i(cor_tick), .wrap_o(sec_tick), .cnt_o(fast_cnt));

  tt_modcnt #(.LIMIT(SEC_PER_MIN)) u_sec (
    .clk(clk), .rst_n(rst_core_n), .en_i(sec_tick), .wrap_o(min_tick), .cnt_o(sec_cnt));

  assign in_sec0  = (sec_cnt == '0);
  assign win_open = cor_tick && in_sec0 && (fast_cnt == WIN_LAST);

  tt_swallow u_swallow (
    .clk(clk), .rst_n(rst_core_n), .raw_tick_i(raw_tick), .open_i(win_open),
    .cal_en_i(cal_en_i), .cal_i(cal_i), .rem_o(rem), .hold_o(hold));

  tt_check #(.BASE(CHK_BASE)) u_check (
    .clk(clk), .rst_n(rst_core_n), .mode_i(chk_mode_i), .raw_tick_i(raw_tick),
    .cal_i(cal_i), .tick_o(chk_tick_o));

  assign fast_tick_o = cor_tick;
  assign sec_tick_o  = sec_tick;
  assign min_tick_o  = min_tick;
endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import tt_pkg::*;
(
  input logic clk,
  input logic rst_core_n,
  input logic cal_en_i,
  input logic chk_mode_i,
  input logic raw_tick,
  input logic in_sec0,
  input cal_t rem,
  input logic fast_tick_o,
  input logic sec_tick_o,
  input logic min_tick_o,
  input logic chk_tick_o
);
  a_r2_fast_single: assert property (@(posedge clk) disable iff (!rst_core_n)
    fast_tick_o |=> !fast_tick_o);

  a_r3_sec_on_fast: assert property (@(posedge clk) disable iff (!rst_core_n)
    sec_tick_o |-> fast_tick_o);

  a_r3_min_on_sec: assert property (@(posedge clk) disable iff (!rst_core_n)
    min_tick_o |-> sec_tick_o);

  a_r4_window_in_sec0: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rem != '0) |-> in_sec0);

  a_r4_one_per_slot: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rem != '0 && raw_tick && cal_en_i) |=> (rem == cal_t'($past(rem) - 1'b1)));

  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cal_en_i |=> (rem == '0));

  a_r8_chk_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    !chk_mode_i |-> !chk_tick_o);
endmodule

bind timebase_trim tt_checker u_tt_checker (
  .clk(clk), .rst_core_n(rst_core_n), .cal_en_i(cal_en_i), .chk_mode_i(chk_mode_i),
  .raw_tick(raw_tick), .in_sec0(in_sec0), .rem(rem), .fast_tick_o(fast_tick_o),
  .sec_tick_o(sec_tick_o), .min_tick_o(min_tick_o), .chk_tick_o(chk_tick_o));

// File: tb/test_timebase_trim.sv
`timescale 1ns/1ps
module test_timebase_trim;
  localparam int P = 4, FPS = 16, SPM = 4, WIN = 2, CB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] cal = 6'd3;
  logic cal_en = 1'b1;
  logic chk_mode = 1'b0;
  logic fast_t, sec_t, min_t, chk_t;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  timebase_trim #(.PRE_DIV(P), .FAST_PER_SEC(FPS), .SEC_PER_MIN(SPM),
                  .WIN_START(WIN), .CHK_BASE(CB)) i_timebase_trim (
    .clk(clk), .rst_n(rst_n), .cal_i(cal), .cal_en_i(cal_en), .chk_mode_i(chk_mode),
    .fast_tick_o(fast_t), .sec_tick_o(sec_t), .min_tick_o(min_t), .chk_tick_o(chk_t));

  localparam int NV = 6;
  localparam int VN   [NV] = '{0, 1, 63, 5, 32, 17};
  localparam int VEN  [NV] = '{1, 1, 1, 0, 1, 1};
  localparam int VEXP [NV] = '{256, 260, 508, 256, 384, 324};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges_until_min(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!min_t && n < 2000);
  endtask

  task automatic edges_until_chk(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!chk_t && n < 2000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t_f1, t_f2, t_f3, t_s1, t_m1, nf, cnt, quiet;
    t_f1 = 0; t_f2 = 0; t_f3 = 0; t_s1 = 0; t_m1 = 0; nf = 0;

    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 reset outputs", {fast_t, sec_t, min_t, chk_t}, 0);
    rst_n = 1'b1;
    for (int j = 1; j <= 300; j++) begin
      @(negedge clk);
      if (fast_t) begin
        nf++;
        if (nf == 1) t_f1 = j;
        if (nf == 2) t_f2 = j;
        if (nf == 3) t_f3 = j;
      end
      if (sec_t && t_s1 == 0) t_s1 = j;
      if (min_t && t_m1 == 0) t_m1 = j;
    end
    check("R1 first fast tick", t_f1, 5);
    check("R2 second fast tick", t_f2, 9);
    check("R4 first window gap n=3", t_f3, 25);
    check("R3 first sec tick", t_s1, 77);
    check("R4 first minute with trim", t_m1, 269);

    // R3/R5/R6: minute lengths from the vector table
    edges_until_min(cnt);
    for (int v = 0; v < NV; v++) begin
      cal = 6'(VN[v]);
      cal_en = VEN[v][0];
      edges_until_min(cnt);
      check(VEN[v] != 0 ? "R3 minute length" : "R6 disabled minute", cnt, VEXP[v]);
    end

    // R5: change after window opened does not touch current minute
    cal = 6'd2; cal_en = 1'b1;
    repeat (40) @(negedge clk);
    cal = 6'd40;
    edges_until_min(cnt);
    check("R5 current minute keeps n=2", cnt + 40, 264);
    edges_until_min(cnt);
    check("R5 next minute takes n=40", cnt, 416);

    // R4/R6: abort of a running deletion
    cal = 6'd63;
    repeat (8) @(negedge clk);
    quiet = 0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      if (fast_t) quiet++;
    end
    check("R4 slots deleted in window", quiet, 0);
    cal_en = 1'b0;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!fast_t && cnt < 50);
    check("R6 abort resumes within PRE_DIV", (cnt <= P) ? 1 : 0, 1);

    // R7: check period
    chk_mode = 1'b1; cal = 6'd5;
    edges_until_chk(cnt);
    edges_until_chk(cnt);
    check("R7 check period n=5", cnt, 52);
    cal = 6'd0;
    edges_until_chk(cnt);
    edges_until_chk(cnt);
    check("R7 check period n=0", cnt, 32);
    cal = 6'd63;
    edges_until_chk(cnt);
    edges_until_chk(cnt);
    check("R7 check period n=63", cnt, 284);

    // R8: check mode off
    chk_mode = 1'b0;
    quiet = 0;
    for (int j = 0; j < 300; j++) begin
      @(negedge clk);
      if (chk_t) quiet++;
    end
    check("R8 no check tick when off", quiet, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule